// File: doc/BRIEF.md
# Mailbox and Doorbell Character Channel

This block is one endpoint of a character link between two bus masters. Each direction uses one 32-bit mailbox register and one doorbell register. To send a character, the local side hands a byte to a small sequencer. The sequencer waits until its transmit mailbox reads zero. It then writes the byte into the mailbox with the top bit set, and in the same cycle it raises the data message code in the outgoing doorbell. The peer reads the mailbox, writes zero back to release it, and acknowledges its doorbell by writing ones to the bits it wants cleared.

In the other direction the peer writes the local receive mailbox and rings the local incoming doorbell with a numeric message code. The interrupt line is high while any enabled doorbell bit is set. Each interrupt is serviced in hardware within a single cycle:
- the code is decoded and acted on,
- the doorbell is cleared as if all ones were written to it,
- a data message copies the mailbox byte into a 256-entry receive ring.

The mailbox is released after a data message unless the ring has passed its near-full level. In that case it stays occupied, which stalls the peer until the local reader drains the ring.

Top module: `mbx_char_link`

## Requirements
- R1: After reset, every mailbox and doorbell reads zero, the ring is empty and not full, `irq` and `link_up` are low, and `tx_ready` is high.
- R2: An accepted character is written to `txmb_q` as 0x80000000 OR the byte, and only in a cycle in which `txmb_q` reads zero. A nonzero `txmb_q` keeps its value until the peer pulses `peer_txmb_clr`, which sets it to zero.
- R3: In the cycle a character is written to `txmb_q`, the data code 5 is ORed into `outbell_q`.
- R4: After a newline (0x0A) is sent, a carriage return (0x0D) is sent automatically as the next mailbox word. `tx_ready` stays low until the carriage return has been written.
- R5: Peer writes to the incoming doorbell are ORed into `inbell_q`. `irq` is high exactly when `inbell_q & bell_en` is nonzero. Bits that are not enabled stay pending and are not serviced.
- R6: In the cycle after `irq` is high, `inbell_q` is cleared. Bits written by the peer in that same cycle are kept.
- R7: A serviced alive message (value 1) sets bit 0 of `outbell_q`.
- R8: A serviced connect message (value 2) sets `link_up`. A serviced disconnect message (value 3) clears it.
- R9: A serviced data message (value 5) pushes `rxmb_q[7:0]` into the ring only when `rxmb_q[31]` is set. Any other doorbell value is cleared without any effect.
- R10: After a push, `rxmb_q` is cleared if the ring holds at most 252 entries. Otherwise `rxmb_q` keeps its value and `ring_full` is set. `ring_full` is high only while more than 252 entries are held.
- R11: When pops bring a full ring down to 252 entries or fewer, `ring_full` clears and `rxmb_q` is cleared in the same cycle.
- R12: The ring delivers bytes in arrival order on `rx_char` while `rx_valid` is high, and `rx_pop` removes one byte. `rx_level` gives the occupancy. The pointers wrap modulo 256. A push is dropped when 256 entries are held.
- R13: `peer_ack_we` clears the bits of `outbell_q` that are set in `peer_ack_data`. Bits raised by the block in the same cycle are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| peer_rxmb_we | input | 1 | Peer writes the receive mailbox |
| peer_rxmb_wdata | input | 32 | Word written to the receive mailbox |
| rxmb_q | output | 32 | Receive mailbox contents |
| peer_bell_we | input | 1 | Peer rings the incoming doorbell |
| peer_bell_wdata | input | 32 | Bits ORed into the incoming doorbell |
| inbell_q | output | 32 | Incoming doorbell contents |
| bell_en | input | 32 | Interrupt enable per incoming doorbell bit |
| irq | output | 1 | Doorbell interrupt |
| txmb_q | output | 32 | Transmit mailbox contents |
| peer_txmb_clr | input | 1 | Peer releases the transmit mailbox |
| outbell_q | output | 32 | Outgoing doorbell contents |
| peer_ack_we | input | 1 | Peer acknowledges outgoing doorbell bits |
| peer_ack_data | input | 32 | Outgoing doorbell bits to clear |
| tx_valid | input | 1 | Local character offered |
| tx_char | input | 8 | Local character |
| tx_ready | output | 1 | Sequencer can accept a character |
| rx_valid | output | 1 | Ring holds at least one byte |
| rx_char | output | 8 | Oldest byte in the ring |
| rx_pop | input | 1 | Remove the oldest byte |
| rx_level | output | 9 | Ring occupancy |
| ring_full | output | 1 | Ring is past its near-full level |
| link_up | output | 1 | Peer is connected |

## Verification
The bench drives the ring through its 252-entry threshold and then past it. A design with an off-by-one threshold would release the mailbox one entry too early or too late. A design without the release on drain would leave the peer stalled for good. A peer that keeps pushing at 256 entries must be dropped; otherwise the ring wraps over unread bytes.

A newline must be followed by exactly one carriage return, and only after the peer has released the mailbox. A sequencer that skipped the free test would overwrite a pending word.

A peer write that lands on the same edge as a doorbell clear must survive. A masked code must stay pending without being acted on. An invalid data word, or an unknown code, must change nothing at all.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int WORD_W = 32;
  localparam int CHAR_W = 8;

  localparam logic [CHAR_W-1:0] CH_LF = 8'h0A;
  localparam logic [CHAR_W-1:0] CH_CR = 8'h0D;

  typedef enum logic [2:0] {
    MSG_NONE       = 3'd0,
    MSG_ALIVE      = 3'd1,
    MSG_CONNECT    = 3'd2,
    MSG_DISCONNECT = 3'd3,
    MSG_DATA       = 3'd5
  } msg_e;

  typedef enum logic {
    TX_IDLE,
    TX_WAIT
  } tx_state_e;

  // Whole doorbell value is the message; anything else decodes to none.
  function automatic msg_e decode_msg(input logic [WORD_W-1:0] bell);
    case (bell)
      WORD_W'(1): return MSG_ALIVE;
      WORD_W'(2): return MSG_CONNECT;
      WORD_W'(3): return MSG_DISCONNECT;
      WORD_W'(5): return MSG_DATA;
      default:    return MSG_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] msg_word(input msg_e m);
    return {{(WORD_W-3){1'b0}}, m};
  endfunction

  // Mailbox word carrying one character: flag in the top bit.
  function automatic logic [WORD_W-1:0] tx_word(input logic [CHAR_W-1:0] ch);
    return {1'b1, {(WORD_W-CHAR_W-1){1'b0}}, ch};
  endfunction

  function automatic logic word_flagged(input logic [WORD_W-1:0] w);
    return w[WORD_W-1];
  endfunction

  function automatic logic level_over(input int lvl, input int depth, input int gap);
    return lvl > (depth - gap);
  endfunction

endpackage

// File: rtl/mbx_bell_reg.sv
module mbx_bell_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic [W-1:0] set_data,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);

  logic [W-1:0] clr_mask;
  logic [W-1:0] set_mask;

  assign clr_mask = clr_we ? clr_data : '0;
  assign set_mask = set_we ? set_data : '0;

  // Write-one-to-clear applies to the old value; new sets always survive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_mask) | set_mask;
  end

endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rel,
  output logic [W-1:0] q
);

  // A write outranks a release in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
    else if (rel)   q <= '0;
  end

endmodule

// File: rtl/mbx_rx_ring.sv
module mbx_rx_ring #(
  parameter  int DEPTH  = 256,
  parameter  int GAP    = 4,
  parameter  int CW     = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int LVL_W  = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [CW-1:0]    push_char,
  input  logic             pop_req,
  output logic [CW-1:0]    rd_char,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             release_mbox
);

  logic [CW-1:0]    store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_next, rd_next;
  logic [LVL_W-1:0] lvl_n;
  logic             push_ok, pop_ok, over_n;

  assign push_ok = push_req && (level != LVL_W'(DEPTH));
  assign pop_ok  = pop_req && (level != '0);

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign wr_next = wr_ptr + AW'(1);
      assign rd_next = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_next = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      assign rd_next = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_comb begin
    lvl_n = level;
    if (push_ok) lvl_n = lvl_n + LVL_W'(1);
    if (pop_ok)  lvl_n = lvl_n - LVL_W'(1);
  end

  assign over_n       = mbx_pkg::level_over(int'(lvl_n), DEPTH, GAP);
  assign release_mbox = (push_ok || full) && !over_n;
  assign rd_char      = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      full   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_next;
      if (pop_ok)  rd_ptr <= rd_next;
      level <= lvl_n;
      full  <= push_ok ? over_n : (full && over_n);
    end
  end

endmodule

// File: rtl/mbx_tx_seq.sv
module mbx_tx_seq
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_char,
  input  logic              mbox_free,
  output logic              tx_ready,
  output logic              send,
  output logic [WORD_W-1:0] send_word
);

  tx_state_e         st;
  logic [CHAR_W-1:0] ch;

  assign tx_ready  = (st == TX_IDLE);
  assign send      = (st == TX_WAIT) && mbox_free;
  assign send_word = tx_word(ch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE;
      ch <= '0;
    end else begin
      case (st)
        TX_IDLE: if (tx_valid) begin
          ch <= tx_char;
          st <= TX_WAIT;
        end
        TX_WAIT: if (mbox_free) begin
          if (ch == CH_LF) ch <= CH_CR;
          else             st <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbx_char_link.sv
module mbx_char_link
  import mbx_pkg::*;
#(
  parameter  int DEPTH = 256,
  parameter  int GAP   = 4,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              peer_rxmb_we,
  input  logic [WORD_W-1:0] peer_rxmb_wdata,
  output logic [WORD_W-1:0] rxmb_q,
  input  logic              peer_bell_we,
  input  logic [WORD_W-1:0] peer_bell_wdata,
  output logic [WORD_W-1:0] inbell_q,
  input  logic [WORD_W-1:0] bell_en,
  output logic              irq,
  output logic [WORD_W-1:0] txmb_q,
  input  logic              peer_txmb_clr,
  output logic [WORD_W-1:0] outbell_q,
  input  logic              peer_ack_we,
  input  logic [WORD_W-1:0] peer_ack_data,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_char,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [CHAR_W-1:0] rx_char,
  input  logic              rx_pop,
  output logic [LVL_W-1:0]  rx_level,
  output logic              ring_full,
  output logic              link_up
);

  // Named internal events, observed by the bound checker.
  logic              svc_act;
  msg_e              svc_msg;
  logic              alive_reply;
  logic              ring_push;
  logic              ring_release;
  logic              tx_send;
  logic [WORD_W-1:0] send_word;
  logic              out_set_we;
  logic [WORD_W-1:0] out_set_data;

  assign svc_act     = |(inbell_q & bell_en);
  assign irq         = svc_act;
  assign svc_msg     = decode_msg(inbell_q);
  assign alive_reply = svc_act && (svc_msg == MSG_ALIVE);
  assign ring_push   = svc_act && (svc_msg == MSG_DATA) && word_flagged(rxmb_q);

  mbx_bell_reg #(.W(WORD_W)) u_inbell (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (peer_bell_we),
    .set_data (peer_bell_wdata),
    .clr_we   (svc_act),
    .clr_data ({WORD_W{1'b1}}),
    .q        (inbell_q)
  );

  assign out_set_we   = tx_send || alive_reply;
  assign out_set_data = (tx_send     ? msg_word(MSG_DATA)  : '0)
                      | (alive_reply ? msg_word(MSG_ALIVE) : '0);

  mbx_bell_reg #(.W(WORD_W)) u_outbell (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (out_set_we),
    .set_data (out_set_data),
    .clr_we   (peer_ack_we),
    .clr_data (peer_ack_data),
    .q        (outbell_q)
  );

  mbx_mailbox #(.W(WORD_W)) u_rxmb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (peer_rxmb_we),
    .wr_data (peer_rxmb_wdata),
    .rel     (ring_release),
    .q       (rxmb_q)
  );

  mbx_mailbox #(.W(WORD_W)) u_txmb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tx_send),
    .wr_data (send_word),
    .rel     (peer_txmb_clr),
    .q       (txmb_q)
  );

  mbx_rx_ring #(.DEPTH(DEPTH), .GAP(GAP), .CW(CHAR_W)) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_req     (ring_push),
    .push_char    (rxmb_q[CHAR_W-1:0]),
    .pop_req      (rx_pop),
    .rd_char      (rx_char),
    .level        (rx_level),
    .full         (ring_full),
    .release_mbox (ring_release)
  );

  assign rx_valid = (rx_level != '0);

  mbx_tx_seq u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_char   (tx_char),
    .mbox_free (txmb_q == '0),
    .tx_ready  (tx_ready),
    .send      (tx_send),
    .send_word (send_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_up <= 1'b0;
    else if (svc_act && svc_msg == MSG_CONNECT)    link_up <= 1'b1;
    else if (svc_act && svc_msg == MSG_DISCONNECT) link_up <= 1'b0;
  end

endmodule

// File: rtl/mbx_link_chk.sv
module mbx_link_chk
  import mbx_pkg::*;
#(
  parameter int LVL_W = 9,
  parameter int DEPTH = 256,
  parameter int GAP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              tx_send,
  input logic [WORD_W-1:0] send_word,
  input logic [WORD_W-1:0] txmb_q,
  input logic              peer_txmb_clr,
  input logic [WORD_W-1:0] outbell_q,
  input logic              tx_ready,
  input logic [WORD_W-1:0] inbell_q,
  input logic              peer_bell_we,
  input logic              ring_full,
  input logic [LVL_W-1:0]  rx_level,
  input logic [WORD_W-1:0] rxmb_q,
  input logic              peer_rxmb_we,
  input logic              link_up
);

  // R2
  txmb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txmb_q != '0 && !peer_txmb_clr) |=> (txmb_q == $past(txmb_q)));

  // R3
  data_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |=> (txmb_q[WORD_W-1] && outbell_q[2] && outbell_q[0]));

  // R4
  cr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_send && send_word == tx_word(CH_LF)) |=> !tx_ready);

  // R6
  bell_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !peer_bell_we) |=> (inbell_q == '0));

  // R8
  link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> ($past(inbell_q) == WORD_W'(2)));

  // R10
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> (int'(rx_level) > DEPTH - GAP));

  // R11
  drain_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ring_full) && !$past(peer_rxmb_we)) |-> (rxmb_q == '0));

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_level) <= DEPTH);

endmodule

bind mbx_char_link mbx_link_chk #(.LVL_W(LVL_W), .DEPTH(DEPTH), .GAP(GAP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq           (irq),
  .tx_send       (tx_send),
  .send_word     (send_word),
  .txmb_q        (txmb_q),
  .peer_txmb_clr (peer_txmb_clr),
  .outbell_q     (outbell_q),
  .tx_ready      (tx_ready),
  .inbell_q      (inbell_q),
  .peer_bell_we  (peer_bell_we),
  .ring_full     (ring_full),
  .rx_level      (rx_level),
  .rxmb_q        (rxmb_q),
  .peer_rxmb_we  (peer_rxmb_we),
  .link_up       (link_up)
);

// File: tb/tb_mbx_char_link.sv
`timescale 1ns/1ps
module tb_mbx_char_link;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        peer_rxmb_we = 1'b0;
  logic [31:0] peer_rxmb_wdata = '0;
  logic [31:0] rxmb_q;
  logic        peer_bell_we = 1'b0;
  logic [31:0] peer_bell_wdata = '0;
  logic [31:0] inbell_q;
  logic [31:0] bell_en = '0;
  logic        irq;
  logic [31:0] txmb_q;
  logic        peer_txmb_clr = 1'b0;
  logic [31:0] outbell_q;
  logic        peer_ack_we = 1'b0;
  logic [31:0] peer_ack_data = '0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_char = '0;
  logic        tx_ready;
  logic        rx_valid;
  logic [7:0]  rx_char;
  logic        rx_pop = 1'b0;
  logic [8:0]  rx_level;
  logic        ring_full;
  logic        link_up;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mbx_char_link dut (.*);

  // ---------------- reference model ----------------
  logic [7:0]  m_ring[$];
  logic [31:0] m_rxmb = '0, m_txmb = '0, m_inb = '0, m_outb = '0;
  bit          m_link = 0, m_full = 0, m_wait = 0;
  logic [7:0]  m_ch = '0;
  bit          s_act, s_push, s_pop, s_over, s_rel, s_send;
  int          s_lvl;
  logic [31:0] s_code;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ring.delete();
      m_rxmb = '0; m_txmb = '0; m_inb = '0; m_outb = '0;
      m_link = 0; m_full = 0; m_wait = 0; m_ch = '0;
    end else begin
      s_act  = (m_inb & bell_en) != 0;
      s_code = m_inb;
      s_push = s_act && s_code == 5 && m_rxmb[31] && m_ring.size() < 256;
      s_pop  = rx_pop && m_ring.size() > 0;
      s_lvl  = m_ring.size() + (s_push ? 1 : 0) - (s_pop ? 1 : 0);
      s_over = s_lvl > 252;
      s_rel  = (s_push || m_full) && !s_over;
      s_send = m_wait && m_txmb == 0;
      if (s_pop)  void'(m_ring.pop_front());
      if (s_push) m_ring.push_back(m_rxmb[7:0]);
      m_full = s_push ? s_over : (m_full && s_over);
      m_rxmb = peer_rxmb_we ? peer_rxmb_wdata : (s_rel ? 32'd0 : m_rxmb);
      m_outb = (m_outb & ~(peer_ack_we ? peer_ack_data : 32'd0))
             | (s_send ? 32'd5 : 32'd0) | ((s_act && s_code == 1) ? 32'd1 : 32'd0);
      m_inb  = (s_act ? 32'd0 : m_inb) | (peer_bell_we ? peer_bell_wdata : 32'd0);
      if (s_act && s_code == 2) m_link = 1;
      if (s_act && s_code == 3) m_link = 0;
      if (s_send) m_txmb = {1'b1, 23'd0, m_ch};
      else if (peer_txmb_clr) m_txmb = '0;
      if (!m_wait && tx_valid) begin
        m_wait = 1; m_ch = tx_char;
      end else if (s_send) begin
        if (m_ch == 8'h0A) m_ch = 8'h0D;
        else m_wait = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    chk("R2 txmb_q", txmb_q, m_txmb);
    chk("R3 outbell_q", outbell_q, m_outb);
    chk("R4 tx_ready", {31'd0, tx_ready}, {31'd0, !m_wait});
    chk("R6 inbell_q", inbell_q, m_inb);
    chk("R5 irq", {31'd0, irq}, {31'd0, (m_inb & bell_en) != 0});
    chk("R8 link_up", {31'd0, link_up}, {31'd0, m_link});
    chk("R10 rxmb_q", rxmb_q, m_rxmb);
    chk("R10 ring_full", {31'd0, ring_full}, {31'd0, m_full});
    chk("R12 rx_level", {23'd0, rx_level}, m_ring.size());
    chk("R12 rx_valid", {31'd0, rx_valid}, {31'd0, m_ring.size() > 0});
    if (m_ring.size() > 0) chk("R12 rx_char", {24'd0, rx_char}, {24'd0, m_ring[0]});
  end

  // ---------------- stimulus tasks ----------------
  task automatic ring_bell(input logic [31:0] code);
    @(negedge clk); peer_bell_we = 1; peer_bell_wdata = code;
    @(negedge clk); peer_bell_we = 0;
    @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    for (int k = 0; k < 50 && !tx_ready; k++) @(negedge clk);
    tx_valid = 1; tx_char = c;
    @(negedge clk); tx_valid = 0;
    @(negedge clk);
  endtask

  task automatic clear_txmb();
    @(negedge clk); peer_txmb_clr = 1;
    @(negedge clk); peer_txmb_clr = 0;
  endtask

  task automatic ack_out();
    @(negedge clk); peer_ack_we = 1; peer_ack_data = 32'hFFFF_FFFF;
    @(negedge clk); peer_ack_we = 0;
  endtask

  task automatic peer_data(input logic [7:0] c);
    @(negedge clk);
    peer_rxmb_we = 1; peer_rxmb_wdata = {1'b1, 23'd0, c};
    peer_bell_we = 1; peer_bell_wdata = 32'd5;
    @(negedge clk); peer_rxmb_we = 0; peer_bell_we = 0;
    @(negedge clk);
  endtask

  task automatic pop1();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 txmb", txmb_q, 0); chk("R1 rxmb", rxmb_q, 0);
    chk("R1 bells", inbell_q | outbell_q, 0);
    chk("R1 flags", {irq, link_up, ring_full, rx_valid, tx_ready}, 32'b00001);
    chk("R1 level", {23'd0, rx_level}, 0);
    rst_n = 1;
    bell_en = '1;

    // R2 / R3 transmit with mailbox busy
    send_char(8'h41);
    chk("R2 first word", txmb_q, 32'h8000_0041);
    chk("R3 data code", outbell_q, 32'd5);
    send_char(8'h42);
    repeat (3) @(negedge clk);
    chk("R2 held while busy", txmb_q, 32'h8000_0041);
    clear_txmb(); @(negedge clk);
    chk("R2 after release", txmb_q, 32'h8000_0042);
    ack_out(); @(negedge clk);
    chk("R13 outbell acked", outbell_q, 0);

    // R4 newline then carriage return
    clear_txmb();
    send_char(8'h0A);
    chk("R4 newline word", txmb_q, 32'h8000_000A);
    chk("R4 not ready", {31'd0, tx_ready}, 0);
    clear_txmb(); @(negedge clk);
    chk("R4 cr word", txmb_q, 32'h8000_000D);
    chk("R4 ready again", {31'd0, tx_ready}, 1);
    clear_txmb(); ack_out();

    // R7 alive, R8 connect/disconnect, R9 unknown code
    ring_bell(32'd1);
    chk("R7 alive reply", outbell_q, 32'd1);
    chk("R6 bell cleared", inbell_q, 0);
    ring_bell(32'd2);
    chk("R8 connect", {31'd0, link_up}, 1);
    ring_bell(32'd7);
    chk("R9 unknown ignored", {inbell_q[30:0], link_up}, 1);
    ring_bell(32'd3);
    chk("R8 disconnect", {31'd0, link_up}, 0);

    // R5 masked doorbell stays pending
    @(negedge clk); bell_en = '0;
    ring_bell(32'd2); @(negedge clk);
    chk("R5 pending", inbell_q, 32'd2);
    chk("R5 no irq", {30'd0, irq, link_up}, 0);
    bell_en = '1; #0.5;
    chk("R5 irq on enable", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R5 serviced", {inbell_q[30:0], link_up}, 1);

    // R9 unflagged data word not pushed
    @(negedge clk); peer_rxmb_we = 1; peer_rxmb_wdata = 32'h41;
    @(negedge clk); peer_rxmb_we = 0;
    ring_bell(32'd5);
    chk("R9 no push", {23'd0, rx_level}, 0);
    chk("R9 mailbox kept", rxmb_q, 32'h41);
    @(negedge clk); peer_rxmb_we = 1; peer_rxmb_wdata = 0;
    @(negedge clk); peer_rxmb_we = 0;

    // R10 fill until back-pressure
    for (int i = 0; i < 300; i++) begin
      if (ring_full) break;
      peer_data(i[7:0]);
    end
    chk("R10 level at full", {23'd0, rx_level}, 253);
    chk("R10 full flag", {31'd0, ring_full}, 1);
    chk("R10 mailbox held", rxmb_q, 32'h8000_00FC);
    // R12 misbehaving peer overruns the ring
    for (int i = 0; i < 4; i++) peer_data(8'hA0 + i[7:0]);
    chk("R12 drop at 256", {23'd0, rx_level}, 256);

    // R11 drain releases mailbox at 252
    for (int i = 0; i < 3; i++) pop1();
    chk("R11 still full", {31'd0, ring_full}, 1);
    pop1();
    chk("R11 full cleared", {31'd0, ring_full}, 0);
    chk("R11 mailbox released", rxmb_q, 0);
    chk("R11 level", {23'd0, rx_level}, 252);
    for (int i = 0; i < 300 && rx_valid; i++) pop1();
    chk("R12 empty", {23'd0, rx_level}, 0);
    for (int i = 0; i < 6; i++) peer_data(8'h60 + i[7:0]);
    chk("R12 wrap head", {24'd0, rx_char}, 32'h60);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      tx_valid        = tx_ready && ($urandom % 3 == 0);
      tx_char         = ($urandom % 8 == 0) ? 8'h0A : 8'(8'h20 + $urandom % 64);
      peer_txmb_clr   = (txmb_q != 0) && ($urandom % 3 == 0);
      peer_ack_we     = ($urandom % 5 == 0);
      peer_ack_data   = $urandom;
      peer_rxmb_we    = (rxmb_q == 0) && ($urandom % 4 == 0);
      peer_rxmb_wdata = {($urandom % 8 != 0), 23'd0, 8'($urandom)};
      peer_bell_we    = ($urandom % 4 == 0);
      case ($urandom % 6)
        0: peer_bell_wdata = 1;
        1: peer_bell_wdata = 2;
        2: peer_bell_wdata = 3;
        3: peer_bell_wdata = 7;
        default: peer_bell_wdata = 5;
      endcase
      rx_pop  = ($urandom % 3 == 0);
      bell_en = ($urandom % 10 == 0) ? 32'd0 : 32'hFFFF_FFFF;
    end
    @(negedge clk);
    tx_valid = 0; peer_txmb_clr = 0; peer_ack_we = 0;
    peer_rxmb_we = 0; peer_bell_we = 0; rx_pop = 0;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule